// File: doc/BRIEF.md
# Reset Mode Entry Controller

After a power-on reset this block decides whether the microcontroller starts in monitor mode or in user mode. It takes three things into account. The first is a flag saying the interrupt pin sits at the high-voltage level. The second is a mode-select pin. The third is whether the two reset-vector bytes in memory are blank. It reads both vector bytes through a simple registered read port, applies the entry rules once and latches the outcome until the next power-on reset.

The latched outcome drives four outputs: a mode flag, a watchdog-disable flag and a select that bypasses the divide-by-two bus-clock prescaler. It also drives a blank-vector flag for the illegal-address reset logic. The block also produces the bus-clock enable: a pulse every cycle when the prescaler is bypassed and every second cycle otherwise. In monitor mode the serial monitor then talks at 9600 baud over a single port pin. The baud logic is outside this block.

Top module: `boot_mode_select`

## Requirements
- R1: After reset is released, `vec_rd` is high for exactly two consecutive cycles, the 3rd and 4th cycles after release. It presents address 16'hFFFE in the first of them and 16'hFFFF in the second. `vec_rdata` is taken one cycle after each request. No other read occurs until the next reset.
- R2: With the high-voltage flag set and the select pin low, the block chooses monitor mode and asserts the prescaler bypass.
- R3: With the high-voltage flag set and the select pin high, the block chooses monitor mode and leaves the prescaler active (divide by two).
- R4: With the high-voltage flag clear and both vector bytes equal to 8'hFF, the block chooses monitor mode with the prescaler active.
- R5: With the high-voltage flag clear and at least one vector byte other than 8'hFF, the block chooses user mode with the prescaler active.
- R6: `wdog_off` is high exactly when monitor mode was chosen.
- R7: During reset, and until `decided` rises, all mode outputs and `bus_en` are low. `decided` rises after the 5th clock edge following reset release and stays high, with all latched outputs unchanged, until the next reset.
- R8: The high-voltage flag and the select pin pass through two synchronizing flops. The values present at the first clock edge after reset release are used, and later changes have no effect.
- R9: Once decided, `vec_blank` is high exactly when both vector bytes read 8'hFF.
- R10: After `decided` rises, `bus_en` is high on every cycle if the prescaler is bypassed. Otherwise it is high on the first decided cycle and then on every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External clock |
| rst_n | input | 1 | Power-on reset, active low |
| hv_irq | input | 1 | Interrupt pin at high-voltage level (asynchronous) |
| sel_pin | input | 1 | Mode-select pin (asynchronous) |
| vec_rd | output | 1 | Vector read request |
| vec_addr | output | AW | Vector read address |
| vec_rdata | input | 8 | Read data, valid one cycle after the request |
| decided | output | 1 | Decision latched |
| mode_monitor | output | 1 | 1 = monitor mode, 0 = user mode |
| wdog_off | output | 1 | Watchdog disable |
| clk_div_bypass | output | 1 | 1 = bus clock equals external clock |
| vec_blank | output | 1 | Both reset-vector bytes read 8'hFF |
| bus_en | output | 1 | Bus-clock enable pulse |

## Verification
The decision is tried with the high-voltage flag set and both select levels, which separates the bypassed clock from the divided one. It is also tried with the flag clear and a blank vector, a vector blank only in its low byte, only in its high byte, and fully programmed. These show that both bytes are compared, that each byte comes from its own address, and that a single FF byte is not taken as blank. A run with the flag set over a blank vector shows that the pin path wins and still reports the blank vector. In every run the pins are flipped just after the sampling edge and again after the decision, which tells a latched decision apart from one that follows the pins.

// File: rtl/boot_mode_select.sv
module boot_mode_select #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] VEC_LO = {{(AW-1){1'b1}}, 1'b0},
  parameter logic [AW-1:0] VEC_HI = {AW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_irq,
  input  logic          sel_pin,
  output logic          vec_rd,
  output logic [AW-1:0] vec_addr,
  input  logic [DW-1:0] vec_rdata,
  output logic          decided,
  output logic          mode_monitor,
  output logic          wdog_off,
  output logic          clk_div_bypass,
  output logic          vec_blank,
  output logic          bus_en
);

  typedef enum logic [2:0] {
    ST_SYNC0, ST_SYNC1, ST_RDLO, ST_RDHI, ST_EVAL, ST_DONE
  } state_t;

  state_t state;
  logic hv_s1, hv_s2, sel_s1, sel_s2;
  logic hv_q, sel_q;
  logic [DW-1:0] lo_q;
  logic mon_q, wd_q, byp_q, blank_q, done_q, ph_q;
  logic blank_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_s1 <= 1'b0; hv_s2 <= 1'b0;
      sel_s1 <= 1'b0; sel_s2 <= 1'b0;
    end else begin
      hv_s1 <= hv_irq; hv_s2 <= hv_s1;
      sel_s1 <= sel_pin; sel_s2 <= sel_s1;
    end
  end

  assign blank_now = (lo_q == {DW{1'b1}}) && (vec_rdata == {DW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_SYNC0;
      hv_q    <= 1'b0;
      sel_q   <= 1'b0;
      lo_q    <= '0;
      mon_q   <= 1'b0;
      wd_q    <= 1'b0;
      byp_q   <= 1'b0;
      blank_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      case (state)
        ST_SYNC0: state <= ST_SYNC1;
        ST_SYNC1: state <= ST_RDLO;
        ST_RDLO: begin
          hv_q  <= hv_s2;
          sel_q <= sel_s2;
          state <= ST_RDHI;
        end
        ST_RDHI: begin
          lo_q  <= vec_rdata;
          state <= ST_EVAL;
        end
        ST_EVAL: begin
          mon_q   <= hv_q | blank_now;
          wd_q    <= hv_q | blank_now;
          byp_q   <= hv_q & ~sel_q;
          blank_q <= blank_now;
          done_q  <= 1'b1;
          state   <= ST_DONE;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b1;
    else if (done_q) ph_q <= ~ph_q;
  end

  assign vec_rd         = (state == ST_RDLO) || (state == ST_RDHI);
  assign vec_addr       = (state == ST_RDHI) ? VEC_HI : VEC_LO;
  assign decided        = done_q;
  assign mode_monitor   = mon_q;
  assign wdog_off       = wd_q;
  assign clk_div_bypass = byp_q;
  assign vec_blank      = blank_q;
  assign bus_en         = done_q & (byp_q | ph_q);

endmodule

// File: rtl/boot_mode_select_chk.sv
module boot_mode_select_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_LO = {{(AW-1){1'b1}}, 1'b0},
  parameter logic [AW-1:0] VEC_HI = {AW{1'b1}}
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vec_rd,
  input logic [AW-1:0] vec_addr,
  input logic          decided,
  input logic          mode_monitor,
  input logic          wdog_off,
  input logic          clk_div_bypass,
  input logic          bus_en
);

  assert_read_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |-> (vec_addr == VEC_LO || vec_addr == VEC_HI));

  assert_no_read_after_R1: assert property (@(posedge clk) disable iff (!rst_n)
    decided |-> !vec_rd);

  assert_bypass_monitor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_div_bypass |-> mode_monitor);

  assert_wdog_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    decided |-> (wdog_off == mode_monitor));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    decided |=> decided && $stable(mode_monitor) && $stable(clk_div_bypass));

  assert_quiet_before_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !decided |-> !bus_en && !mode_monitor && !wdog_off);

  assert_bypass_every_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (decided && clk_div_bypass) |-> bus_en);

  assert_div_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (decided && !clk_div_bypass && $past(decided)) |-> (bus_en != $past(bus_en)));

endmodule

bind boot_mode_select boot_mode_select_chk #(.AW(AW), .VEC_LO(VEC_LO), .VEC_HI(VEC_HI)) chk (
  .clk(clk), .rst_n(rst_n), .vec_rd(vec_rd), .vec_addr(vec_addr),
  .decided(decided), .mode_monitor(mode_monitor), .wdog_off(wdog_off),
  .clk_div_bypass(clk_div_bypass), .bus_en(bus_en)
);

// File: tb/boot_mode_select_test.sv
`timescale 1ns/1ps
module boot_mode_select_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hv_irq = 1'b0, sel_pin = 1'b0;
  logic vec_rd;
  logic [15:0] vec_addr;
  logic [7:0] vec_rdata = 8'h00;
  logic decided, mode_monitor, wdog_off, clk_div_bypass, vec_blank, bus_en;
  logic [7:0] lo_val = 8'h00, hi_val = 8'h00;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  boot_mode_select uut (
    .clk(clk), .rst_n(rst_n), .hv_irq(hv_irq), .sel_pin(sel_pin),
    .vec_rd(vec_rd), .vec_addr(vec_addr), .vec_rdata(vec_rdata),
    .decided(decided), .mode_monitor(mode_monitor), .wdog_off(wdog_off),
    .clk_div_bypass(clk_div_bypass), .vec_blank(vec_blank), .bus_en(bus_en)
  );

  always_ff @(posedge clk)
    if (vec_rd)
      vec_rdata <= (vec_addr == 16'hFFFE) ? lo_val :
                   (vec_addr == 16'hFFFF) ? hi_val : 8'h00;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input string name, input logic hv, input logic sel,
                          input logic [7:0] lo, input logic [7:0] hi);
    logic exp_blank, exp_mon, exp_byp;
    exp_blank = (lo == 8'hFF) && (hi == 8'hFF);
    exp_mon   = hv | exp_blank;
    exp_byp   = hv & ~sel;
    @(negedge clk);
    rst_n = 1'b0; hv_irq = hv; sel_pin = sel; lo_val = lo; hi_val = hi;
    repeat (3) @(negedge clk);
    check({name, " R7 reset decided"}, decided, 0);
    check({name, " R7 reset bus_en"}, bus_en, 0);
    check({name, " R7 reset mode"}, {mode_monitor, wdog_off, clk_div_bypass}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    hv_irq = ~hv; sel_pin = ~sel;
    check({name, " R1 no read yet"}, vec_rd, 0);
    @(negedge clk);
    check({name, " R1 first read"}, {vec_rd, vec_addr}, {1'b1, 16'hFFFE});
    @(negedge clk);
    check({name, " R1 second read"}, {vec_rd, vec_addr}, {1'b1, 16'hFFFF});
    @(negedge clk);
    check({name, " R1 reads end"}, vec_rd, 0);
    check({name, " R7 not decided yet"}, {decided, bus_en, mode_monitor}, 0);
    @(negedge clk);
    check({name, " R7 decided"}, decided, 1);
    check({name, " R2 R3 R4 R5 mode"}, mode_monitor, exp_mon);
    check({name, " R2 R3 bypass"}, clk_div_bypass, exp_byp);
    check({name, " R6 wdog"}, wdog_off, exp_mon);
    check({name, " R9 blank"}, vec_blank, exp_blank);
    for (int k = 0; k < 6; k++) begin
      check({name, " R10 bus_en"}, bus_en, ((k % 2) == 0) ? 1'b1 : exp_byp);
      @(negedge clk);
    end
    hv_irq = ~hv_irq; sel_pin = ~sel_pin;
    repeat (4) @(negedge clk);
    check({name, " R8 R7 held"}, {decided, mode_monitor, wdog_off, clk_div_bypass, vec_blank},
          {1'b1, exp_mon, exp_mon, exp_byp, exp_blank});
    check({name, " R1 no late read"}, vec_rd, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    run_case("hv_sel_low", 1'b1, 1'b0, 8'h12, 8'h34);
    run_case("hv_sel_high", 1'b1, 1'b1, 8'h12, 8'h34);
    run_case("blank_vec", 1'b0, 1'b0, 8'hFF, 8'hFF);
    run_case("blank_vec_sel", 1'b0, 1'b1, 8'hFF, 8'hFF);
    run_case("lo_only_ff", 1'b0, 1'b0, 8'hFF, 8'h80);
    run_case("hi_only_ff", 1'b0, 1'b1, 8'h00, 8'hFF);
    run_case("programmed", 1'b0, 1'b0, 8'hC0, 8'h00);
    run_case("hv_over_blank", 1'b1, 1'b0, 8'hFF, 8'hFF);
    run_case("hv_high_blank", 1'b1, 1'b1, 8'hFF, 8'hFF);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule